// File: doc/BRIEF.md
# Video Pixel-Bus Formatter with Double-Data-Rate Demultiplexer

This block sits at the entry of a video pixel input port. It receives a 24-bit parallel pixel bus that it treats as three 8-bit channels: Top (bits 23:16), Middle (bits 15:8) and Bottom (bits 7:0). A 3-bit order control picks which input channel drives each of the three output channel positions. In every single-data-rate format the reordered channels are registered and presented on three output words, zero-extended.

Three format codes select a single-bus 4:2:2 double-data-rate mode, where one sample is carried on each clock edge. The block captures the falling-edge sample in a negative-edge register and re-times it into the rising-edge domain. It then presents a luma/chroma pair at full rate on the rising clock. Two further bits control this pairing. A swap bit chooses which edge carries luma. A pairing bit chooses whether the falling-edge sample is joined to the rising-edge sample before it or to the one after it.

Top module: `vid_bus_fmt`

## Requirements
- R1: While `rst` is high at a rising edge, all three output words and `out_valid` are 0 after that edge. After `rst` is first sampled low at a rising edge, `out_valid` is 1 from the second rising edge onward, and every rising edge after that.
- R2: The order code `chan_order` gives output sources as {top, mid, bot}: 000 T,M,B; 001 T,B,M; 010 T,M,B; 011 M,T,B; 100 B,T,M; 101 B,M,T; 110 M,B,T; 111 T,M,B. Here T = pix_in[23:16], M = pix_in[15:8] and B = pix_in[7:0].
- R3: Order codes 000, 010 and 111 give identical outputs for identical inputs, and that output is the unswapped order.
- R4: In a single-data-rate format, the data and controls sampled at rising edge k appear after rising edge k+1. `out_top`, `out_mid` and `out_bot` hold the reordered top, mid and bot channels in their low 8 bits, and their upper bits are 0.
- R5: `fmt_sel` values 0x09, 0x0A and 0x0B select double-data-rate mode with sample widths of 8, 10 and 12 bits. Each sample is the low W bits of the reordered 24-bit word {top,mid,bot}. Luma goes on `out_top` and chroma on `out_mid`, both zero-extended. `out_bot` is 0.
- R6: In double-data-rate mode with `yc_swap`=0, luma comes from the rising-edge sample and chroma from the falling-edge sample.
- R7: In double-data-rate mode with `yc_swap`=1, chroma comes from the rising-edge sample and luma from the falling-edge sample.
- R8: In double-data-rate mode, the rising-edge sample at edge k is paired as follows. With `late_pair`=0 it is paired with the falling edge just after edge k. With `late_pair`=1 it is paired with the falling edge just before edge k, and that falling sample is 0 if it was captured during reset. The output appears after rising edge k+1.
- R9: In a single-data-rate format, `yc_swap` and `late_pair` have no effect on any output.
- R10: `fmt_sel` values 0x00 to 0x08 and 0x0C to 0x1F all behave as the single-data-rate format of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges capture data |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 24 | Pixel bus, three 8-bit channels |
| fmt_sel | input | 5 | Bus format code |
| chan_order | input | 3 | Channel reorder code |
| yc_swap | input | 1 | Put luma on the falling-edge sample in double-data-rate mode |
| late_pair | input | 1 | Pair the falling sample with the following rising sample |
| out_top | output | 12 | Output word for the top position, or luma |
| out_mid | output | 12 | Output word for the middle position, or chroma |
| out_bot | output | 12 | Output word for the bottom position, 0 in double-data-rate mode |
| out_valid | output | 1 | Output words are valid |

## Verification
Every stage of the datapath is a single register, so a wrong internal value reaches the output words one or two rising edges after the sample that caused it. A corrupted falling-edge register would show up as a wrong chroma or luma word on the next pair. A stale re-timed falling sample would show up only when `late_pair` is set, as a pair whose falling half is one cycle old. A wrong registered control would apply the previous mode's masking or reordering for exactly one output cycle. The bench therefore compares all four outputs against a behavioural model on every rising edge, across every order code and format class.

// File: rtl/vbf_pkg.sv
`timescale 1ns/1ps
package vbf_pkg;

  typedef struct packed {
    logic [4:0] fmt;
    logic [2:0] order;
    logic       yc_swap;
    logic       late;
  } ctrl_t;

  localparam logic [4:0] FMT_DDR8  = 5'h09;
  localparam logic [4:0] FMT_DDR10 = 5'h0A;
  localparam logic [4:0] FMT_DDR12 = 5'h0B;

  function automatic logic is_ddr(input logic [4:0] fmt);
    return (fmt == FMT_DDR8) || (fmt == FMT_DDR10) || (fmt == FMT_DDR12);
  endfunction

  function automatic int ddr_bits(input logic [4:0] fmt);
    case (fmt)
      FMT_DDR10: return 10;
      FMT_DDR12: return 12;
      default:   return 8;
    endcase
  endfunction

  // source index per output position: 0 = top input, 1 = mid, 2 = bottom
  function automatic logic [1:0] src_of(input logic [2:0] code, input int pos);
    logic [5:0] tbl;
    case (code)
      3'b001:  tbl = {2'd0, 2'd2, 2'd1};
      3'b011:  tbl = {2'd1, 2'd0, 2'd2};
      3'b100:  tbl = {2'd2, 2'd0, 2'd1};
      3'b101:  tbl = {2'd2, 2'd1, 2'd0};
      3'b110:  tbl = {2'd1, 2'd2, 2'd0};
      default: tbl = {2'd0, 2'd1, 2'd2};
    endcase
    return tbl[(2-pos)*2 +: 2];
  endfunction

endpackage

// File: rtl/vbf_chan_perm.sv
`timescale 1ns/1ps
module vbf_chan_perm
  import vbf_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic [3*CH_W-1:0] bus_i,
  input  logic [2:0]        order_i,
  output logic [3*CH_W-1:0] perm_o
);
  localparam int BUS_W = 3 * CH_W;

  logic [CH_W-1:0] ch_t, ch_m, ch_b;
  assign ch_t = bus_i[BUS_W-1 -: CH_W];
  assign ch_m = bus_i[2*CH_W-1 -: CH_W];
  assign ch_b = bus_i[CH_W-1:0];

  for (genvar p = 0; p < 3; p++) begin : g_pos
    logic [1:0]      sel;
    logic [CH_W-1:0] word;
    assign sel = src_of(order_i, p);
    always_comb begin
      case (sel)
        2'd0:    word = ch_t;
        2'd1:    word = ch_m;
        default: word = ch_b;
      endcase
    end
    assign perm_o[(3-p)*CH_W-1 -: CH_W] = word;
  end

  // R3: redundant identity codes pass the bus unchanged
  always_comb begin
    if (order_i == 3'b000 || order_i == 3'b010 || order_i == 3'b111)
      a_identity_r3: assert (perm_o == bus_i);
  end

endmodule

// File: rtl/vbf_ddr_capture.sv
`timescale 1ns/1ps
module vbf_ddr_capture
  import vbf_pkg::*;
#(
  parameter int BUS_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] data_i,
  input  ctrl_t            ctrl_i,
  output logic [BUS_W-1:0] rise_q,
  output logic [BUS_W-1:0] fall_now,
  output logic [BUS_W-1:0] fall_prev,
  output ctrl_t            ctrl_q,
  output logic             stage_v
);

  always_ff @(negedge clk) begin
    if (rst) fall_now <= '0;
    else     fall_now <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q    <= '0;
      fall_prev <= '0;
      ctrl_q    <= '0;
      stage_v   <= 1'b0;
    end else begin
      rise_q    <= data_i;
      fall_prev <= fall_now;
      ctrl_q    <= ctrl_i;
      stage_v   <= 1'b1;
    end
  end

  // R1: the capture stage is valid on the edge after reset is first seen low
  p_stage_v_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> stage_v);

endmodule

// File: rtl/vbf_out_stage.sv
`timescale 1ns/1ps
module vbf_out_stage
  import vbf_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3*CH_W-1:0] rise_q,
  input  logic [3*CH_W-1:0] fall_now,
  input  logic [3*CH_W-1:0] fall_prev,
  input  ctrl_t            ctrl_q,
  input  logic             stage_v,
  output logic [OUT_W-1:0] top_o,
  output logic [OUT_W-1:0] mid_o,
  output logic [OUT_W-1:0] bot_o,
  output logic             valid_o
);
  localparam int BUS_W = 3 * CH_W;
  localparam logic [OUT_W-1:0] ONES = '1;

  logic             ddr;
  logic [OUT_W-1:0] msk, r_s, f_s;
  logic [BUS_W-1:0] f_sel;
  logic [OUT_W-1:0] nx_top, nx_mid, nx_bot;

  assign ddr   = is_ddr(ctrl_q.fmt);
  assign msk   = ONES >> (OUT_W - ddr_bits(ctrl_q.fmt));
  assign f_sel = ctrl_q.late ? fall_prev : fall_now;
  assign r_s   = rise_q[OUT_W-1:0] & msk;
  assign f_s   = f_sel[OUT_W-1:0] & msk;

  always_comb begin
    if (ddr) begin
      nx_top = ctrl_q.yc_swap ? f_s : r_s;
      nx_mid = ctrl_q.yc_swap ? r_s : f_s;
      nx_bot = '0;
    end else begin
      nx_top = OUT_W'(rise_q[BUS_W-1 -: CH_W]);
      nx_mid = OUT_W'(rise_q[2*CH_W-1 -: CH_W]);
      nx_bot = OUT_W'(rise_q[CH_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_o   <= '0;
      mid_o   <= '0;
      bot_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      top_o   <= nx_top;
      mid_o   <= nx_mid;
      bot_o   <= nx_bot;
      valid_o <= stage_v;
    end
  end

  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (!valid_o && top_o == '0 && mid_o == '0 && bot_o == '0));

  p_ddr_bot_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ddr |=> bot_o == '0);

  p_ddr8_hi_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.fmt == FMT_DDR8) |=> (top_o[OUT_W-1:8] == '0 && mid_o[OUT_W-1:8] == '0));

  p_chroma_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (ddr && ctrl_q.yc_swap) |=> mid_o[7:0] == $past(rise_q[7:0]));

  p_luma_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (ddr && !ctrl_q.yc_swap) |=> top_o[7:0] == $past(rise_q[7:0]));

  if (OUT_W > CH_W) begin : g_sdr_hi
    p_sdr_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
      !ddr |=> (top_o[OUT_W-1:CH_W] == '0 && mid_o[OUT_W-1:CH_W] == '0
                && bot_o[OUT_W-1:CH_W] == '0));
  end

endmodule

// File: rtl/vid_bus_fmt.sv
`timescale 1ns/1ps
module vid_bus_fmt
  import vbf_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int OUT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3*CH_W-1:0] pix_in,
  input  logic [4:0]        fmt_sel,
  input  logic [2:0]        chan_order,
  input  logic              yc_swap,
  input  logic              late_pair,
  output logic [OUT_W-1:0]  out_top,
  output logic [OUT_W-1:0]  out_mid,
  output logic [OUT_W-1:0]  out_bot,
  output logic              out_valid
);
  localparam int BUS_W = 3 * CH_W;

  ctrl_t            ctrl_in, ctrl_q;
  logic [BUS_W-1:0] perm, rise_q, fall_now, fall_prev;
  logic             stage_v;

  assign ctrl_in = '{fmt: fmt_sel, order: chan_order, yc_swap: yc_swap, late: late_pair};

  vbf_chan_perm #(.CH_W(CH_W)) u_perm (
    .bus_i   (pix_in),
    .order_i (chan_order),
    .perm_o  (perm)
  );

  vbf_ddr_capture #(.BUS_W(BUS_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .data_i    (perm),
    .ctrl_i    (ctrl_in),
    .rise_q    (rise_q),
    .fall_now  (fall_now),
    .fall_prev (fall_prev),
    .ctrl_q    (ctrl_q),
    .stage_v   (stage_v)
  );

  vbf_out_stage #(.CH_W(CH_W), .OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .rise_q    (rise_q),
    .fall_now  (fall_now),
    .fall_prev (fall_prev),
    .ctrl_q    (ctrl_q),
    .stage_v   (stage_v),
    .top_o     (out_top),
    .mid_o     (out_mid),
    .bot_o     (out_bot),
    .valid_o   (out_valid)
  );

  p_valid_hold_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && out_valid) |=> out_valid);

endmodule

// File: tb/vid_bus_fmt_tb.sv
`timescale 1ns/1ps
module vid_bus_fmt_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pix_in = '0;
  logic [4:0]  fmt_sel = '0;
  logic [2:0]  chan_order = '0;
  logic        yc_swap = 1'b0;
  logic        late_pair = 1'b0;
  logic [11:0] out_top, out_mid, out_bot;
  logic        out_valid;

  int checks = 0;
  int errors = 0;

  vid_bus_fmt u_dut (
    .clk(clk), .rst(rst), .pix_in(pix_in), .fmt_sel(fmt_sel),
    .chan_order(chan_order), .yc_swap(yc_swap), .late_pair(late_pair),
    .out_top(out_top), .out_mid(out_mid), .out_bot(out_bot), .out_valid(out_valid)
  );

  always #4 clk = ~clk;

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [23:0] ref_perm(input logic [23:0] d, input logic [2:0] c);
    logic [7:0] t, m, b;
    t = d[23:16]; m = d[15:8]; b = d[7:0];
    case (c)
      3'd1: return {t, b, m};
      3'd3: return {m, t, b};
      3'd4: return {b, t, m};
      3'd5: return {b, m, t};
      3'd6: return {m, b, t};
      default: return d;
    endcase
  endfunction

  function automatic int ref_w(input logic [4:0] f);
    if (f == 5'd9)  return 8;
    if (f == 5'd10) return 10;
    if (f == 5'd11) return 12;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  logic [23:0] pr [0:63];
  logic [23:0] pf [0:63];

  task automatic check_zero(input string tag);
    chk(tag, "valid", {11'd0, out_valid}, 12'd0);
    chk(tag, "top", out_top, 12'd0);
    chk(tag, "mid", out_mid, 12'd0);
    chk(tag, "bot", out_bot, 12'd0);
  endtask

  task automatic run_seg(input logic [4:0] f, input logic [2:0] o, input logic ys, input logic lp, input int n);
    string tag;
    int w;
    logic [23:0] fs;
    logic [11:0] rm, fm, e_t, e_m, e_b, msk;
    w = ref_w(f);
    if (w != 0) tag = lp ? "R8" : (ys ? "R7" : (w == 8 ? "R6" : "R5"));
    else if (f > 5'd12) tag = "R10";
    else if (ys || lp) tag = "R9";
    else if (o == 3'd0 || o == 3'd2 || o == 3'd7) tag = "R3";
    else tag = (o[0] ? "R2" : "R4");
    @(negedge clk); #2;
    rst = 1'b1; pix_in = $urandom;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      check_zero("R1");
    end
    for (int k = 0; k <= n; k++) begin
      @(negedge clk); #2;
      rst = 1'b0; fmt_sel = f; chan_order = o; yc_swap = ys; late_pair = lp;
      pix_in = $urandom;
      pr[k] = ref_perm(pix_in, o);
      @(posedge clk); #1;
      if (k == 0) check_zero("R1");
      else begin
        chk("R1", "valid", {11'd0, out_valid}, 12'd1);
        if (w != 0) begin
          msk = 12'hFFF >> (12 - w);
          fs = lp ? ((k - 1 == 0) ? 24'd0 : pf[k-2]) : pf[k-1];
          rm = pr[k-1][11:0] & msk;
          fm = fs[11:0] & msk;
          e_t = ys ? fm : rm;
          e_m = ys ? rm : fm;
          e_b = 12'd0;
        end else begin
          e_t = {4'd0, pr[k-1][23:16]};
          e_m = {4'd0, pr[k-1][15:8]};
          e_b = {4'd0, pr[k-1][7:0]};
        end
        chk(tag, "top", out_top, e_t);
        chk(tag, "mid", out_mid, e_m);
        chk(tag, "bot", out_bot, e_b);
      end
      #1;
      pix_in = $urandom;
      pf[k] = ref_perm(pix_in, o);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_zero("R1");
    // every order code in a plain SDR format
    for (int o = 0; o < 8; o++) run_seg(5'd0, 3'(o), 1'b0, 1'b0, 12);
    // other SDR formats, with DDR-only controls set (must be ignored)
    run_seg(5'd5,  3'd4, 1'b1, 1'b0, 12);
    run_seg(5'd8,  3'd6, 1'b0, 1'b1, 12);
    run_seg(5'd12, 3'd3, 1'b1, 1'b1, 12);
    run_seg(5'd2,  3'd1, 1'b1, 1'b1, 12);
    // out-of-range codes fall back to SDR
    run_seg(5'd13, 3'd5, 1'b0, 1'b0, 12);
    run_seg(5'd31, 3'd1, 1'b1, 1'b1, 12);
    // DDR widths, swap and pairing variants
    for (int f = 9; f <= 11; f++)
      for (int m = 0; m < 4; m++)
        for (int o = 0; o < 8; o += 3)
          run_seg(5'(f), 3'(o), m[0], m[1], 10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule